// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns 32-bit virtual addresses issued by a device into physical addresses. A requester hands over one address and an access direction (read or write). The block first looks in a small fully associative translation cache. On a miss it walks a two-level table in memory through a word-read port: one read for the first-level entry, one for the second-level entry. It then checks the present and permission bits and answers with the physical address and the cache-attribute hints of the page, or with a fault.

The virtual address splits 10/10/12. The upper ten bits index the first-level table, the next ten bits index the second-level table, and the low twelve bits are the byte offset inside a 4 KiB page. Each table entry is one 32-bit word and each table fills one 4 KiB page. Only 4 KiB pages exist.

Two kinds of failure are reported apart. A missing entry or a refused access is a page fault. An error response on a table read is a bus error. Both carry the faulting address and direction. The cache can be emptied in one cycle, or a single virtual page can be dropped from it. One translation is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req` and `rsp_ack` are 0.
- R2: On a miss the first read goes to `{tbl_pn, va[31:22], 2'b00}`. The second read goes to `{L1[31:12], va[21:12], 2'b00}`, where L1 is the first-level word. Bits 11:1 of the first-level word are ignored.
- R3: Bit 0 of a table word marks it present. If bit 0 is clear at either level, the response has `rsp_fault`=1, with `rsp_paddr` and `rsp_attr` equal to 0.
- R4: A granted translation returns `rsp_paddr = {L2[31:12], va[11:0]}` and `rsp_attr = L2[8:3]`, where L2 is the second-level word.
- R5: In the second-level word, bit 1 allows reads and bit 2 allows writes. An access whose direction bit is 0 gives a page fault. The entry is still cached.
- R6: `mem_err` on either table read ends the walk with `rsp_buserr`=1 and `rsp_fault`=0. Nothing is cached, so a repeat of the same address walks again.
- R7: An address whose page is cached is answered with no memory read. The result equals the walked result, permission check included.
- R8: The cache holds 8 pages, filled in round-robin order. The ninth distinct fill evicts the page filled first.
- R9: A one-cycle `flush_all` pulse drops every cached page, so each page then walks again.
- R10: A one-cycle `inval_en` pulse drops only the page equal to `inval_vpn`. Other cached pages still hit.
- R11: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the cycle after the one-cycle `rsp_ack`. `mem_req` and `mem_addr` hold until `mem_ack`.
- R12: Every response carries the request's address on `rsp_vaddr` and its direction on `rsp_write`. This includes fault and bus-error responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this edge |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| tbl_pn | input | 20 | Page number of the first-level table |
| rsp_ack | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on failure) |
| rsp_attr | output | 6 | Cache-attribute hints of the page |
| rsp_fault | output | 1 | Page fault: missing entry or refused access |
| rsp_buserr | output | 1 | Table read returned an error |
| rsp_vaddr | output | 32 | Address of the answered request |
| rsp_write | output | 1 | Direction of the answered request |
| mem_req | output | 1 | Table word read request |
| mem_addr | output | 32 | Byte address of the table word |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Table word |
| mem_err | input | 1 | Error on this read |
| flush_all | input | 1 | Drop all cached pages |
| inval_en | input | 1 | Drop one cached page |
| inval_vpn | input | 20 | Virtual page to drop |

## Verification
A wrong valid bit or a wrong replacement pointer in the cache shows up at the memory port. The next access to an affected page makes a different number of table reads than expected (zero or two), and the bench counts reads for every translation. A stale or mis-stored cache entry shows up on the first hit that follows, as a wrong physical address, wrong attribute bits or a wrong fault decision. A wrong walk state shows up within the same translation as a bad table address, a missing or repeated acknowledge, or a fault of the wrong kind.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 32;
  localparam int OFS_W    = 12;
  localparam int IDX_W    = 10;
  localparam int PN_W     = VA_W - OFS_W;
  localparam int ATTR_W   = 6;
  localparam int ATTR_LSB = 3;
  localparam int PRES_BIT = 0;
  localparam int RD_BIT   = 1;
  localparam int WR_BIT   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_L1,
    ST_L2,
    ST_RESP
  } ptw_state_e;

  typedef struct packed {
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   ppn;
    logic [ATTR_W-1:0] attr;
    logic              wr_ok;
    logic              rd_ok;
  } ptw_tc_ent_t;
endpackage

// File: rtl/ptw_tcache.sv
module ptw_tcache
  import ptw_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PN_W-1:0] lk_vpn,
  output logic            lk_hit,
  output ptw_tc_ent_t     lk_ent,
  input  logic            fill_en,
  input  ptw_tc_ent_t     fill_ent,
  input  logic            flush,
  input  logic            inval_en,
  input  logic [PN_W-1:0] inval_vpn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d, hit_vec, inv_vec, fill_vec;
  ptw_tc_ent_t [ENTRIES-1:0] ent_q;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    assign hit_vec[gi]  = vld_q[gi] && (ent_q[gi].vpn == lk_vpn);
    assign inv_vec[gi]  = inval_en && vld_q[gi] && (ent_q[gi].vpn == inval_vpn);
    assign fill_vec[gi] = fill_en && (ptr_q == PTR_W'(gi));
  end

  // Invalidation first, a fill in the same cycle wins for its own slot.
  always_comb begin
    vld_d = (vld_q & ~inv_vec & {ENTRIES{~flush}}) | fill_vec;
    ptr_d = ptr_q;
    if (fill_en) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    lk_ent = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) lk_ent = lk_ent | ent_q[i];
    lk_hit = |hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++)
      if (fill_vec[i]) ent_q[i] <= fill_ent;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [PN_W-1:0]   tbl_pn,
  output logic              req_ready,
  output logic [PN_W-1:0]   lk_vpn,
  input  logic              lk_hit,
  input  ptw_tc_ent_t       lk_ent,
  output logic              fill_en,
  output ptw_tc_ent_t       fill_ent,
  output logic              mem_req,
  output logic [VA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [VA_W-1:0]   mem_rdata,
  input  logic              mem_err,
  output logic              rsp_ack,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_fault,
  output logic              rsp_buserr,
  output logic [VA_W-1:0]   rsp_vaddr,
  output logic              rsp_write
);
  ptw_state_e        st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [PN_W-1:0]   l2pn_q;
  logic [VA_W-1:0]   paddr_q, paddr_d;
  logic [ATTR_W-1:0] attr_q, attr_d;
  logic              flt_q, flt_d, berr_q, berr_d;
  logic              va_en, l2pn_en, rsp_en;
  logic              unused_rdata;

  assign unused_rdata = ^mem_rdata[OFS_W-1:ATTR_LSB+ATTR_W];

  assign req_ready = (st_q == ST_IDLE);
  assign lk_vpn    = va_q[VA_W-1:OFS_W];
  assign mem_req   = (st_q == ST_L1) || (st_q == ST_L2);
  assign mem_addr  = (st_q == ST_L1) ? {tbl_pn, va_q[VA_W-1 -: IDX_W], 2'b00}
                                     : {l2pn_q, va_q[OFS_W +: IDX_W], 2'b00};

  assign fill_ent.vpn   = va_q[VA_W-1:OFS_W];
  assign fill_ent.ppn   = mem_rdata[VA_W-1:OFS_W];
  assign fill_ent.attr  = mem_rdata[ATTR_LSB +: ATTR_W];
  assign fill_ent.wr_ok = mem_rdata[WR_BIT];
  assign fill_ent.rd_ok = mem_rdata[RD_BIT];

  always_comb begin
    st_d    = st_q;
    va_en   = 1'b0;
    l2pn_en = 1'b0;
    rsp_en  = 1'b0;
    fill_en = 1'b0;
    paddr_d = '0;
    attr_d  = '0;
    flt_d   = 1'b0;
    berr_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        va_en = 1'b1;
        st_d  = ST_LOOK;
      end
      ST_LOOK: begin
        if (lk_hit) begin
          rsp_en = 1'b1;
          st_d   = ST_RESP;
          if (wr_q ? lk_ent.wr_ok : lk_ent.rd_ok) begin
            paddr_d = {lk_ent.ppn, va_q[OFS_W-1:0]};
            attr_d  = lk_ent.attr;
          end else begin
            flt_d = 1'b1;
          end
        end else begin
          st_d = ST_L1;
        end
      end
      ST_L1: if (mem_ack) begin
        if (mem_err || !mem_rdata[PRES_BIT]) begin
          rsp_en = 1'b1;
          berr_d = mem_err;
          flt_d  = !mem_err;
          st_d   = ST_RESP;
        end else begin
          l2pn_en = 1'b1;
          st_d    = ST_L2;
        end
      end
      ST_L2: if (mem_ack) begin
        rsp_en = 1'b1;
        st_d   = ST_RESP;
        if (mem_err) begin
          berr_d = 1'b1;
        end else if (!mem_rdata[PRES_BIT]) begin
          flt_d = 1'b1;
        end else begin
          fill_en = 1'b1;
          if (wr_q ? mem_rdata[WR_BIT] : mem_rdata[RD_BIT]) begin
            paddr_d = {mem_rdata[VA_W-1:OFS_W], va_q[OFS_W-1:0]};
            attr_d  = mem_rdata[ATTR_LSB +: ATTR_W];
          end else begin
            flt_d = 1'b1;
          end
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      l2pn_q  <= '0;
      paddr_q <= '0;
      attr_q  <= '0;
      flt_q   <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (va_en) begin
        va_q <= req_vaddr;
        wr_q <= req_write;
      end
      if (l2pn_en) l2pn_q <= mem_rdata[VA_W-1:OFS_W];
      if (rsp_en) begin
        paddr_q <= paddr_d;
        attr_q  <= attr_d;
        flt_q   <= flt_d;
        berr_q  <= berr_d;
      end
    end
  end

  assign rsp_ack    = (st_q == ST_RESP);
  assign rsp_paddr  = paddr_q;
  assign rsp_attr   = attr_q;
  assign rsp_fault  = flt_q;
  assign rsp_buserr = berr_q;
  assign rsp_vaddr  = va_q;
  assign rsp_write  = wr_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int TC_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [PN_W-1:0]   tbl_pn,
  output logic              rsp_ack,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_fault,
  output logic              rsp_buserr,
  output logic [VA_W-1:0]   rsp_vaddr,
  output logic              rsp_write,
  output logic              mem_req,
  output logic [VA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [VA_W-1:0]   mem_rdata,
  input  logic              mem_err,
  input  logic              flush_all,
  input  logic              inval_en,
  input  logic [PN_W-1:0]   inval_vpn
);
  logic [PN_W-1:0] lk_vpn;
  logic            lk_hit, fill_en;
  ptw_tc_ent_t     lk_ent, fill_ent;

  ptw_tcache #(.ENTRIES(TC_ENTRIES)) u_tcache (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vpn    (lk_vpn),
    .lk_hit    (lk_hit),
    .lk_ent    (lk_ent),
    .fill_en   (fill_en),
    .fill_ent  (fill_ent),
    .flush     (flush_all),
    .inval_en  (inval_en),
    .inval_vpn (inval_vpn)
  );

  ptw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .tbl_pn     (tbl_pn),
    .req_ready  (req_ready),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_ent     (lk_ent),
    .fill_en    (fill_en),
    .fill_ent   (fill_ent),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_err    (mem_err),
    .rsp_ack    (rsp_ack),
    .rsp_paddr  (rsp_paddr),
    .rsp_attr   (rsp_attr),
    .rsp_fault  (rsp_fault),
    .rsp_buserr (rsp_buserr),
    .rsp_vaddr  (rsp_vaddr),
    .rsp_write  (rsp_write)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_ack,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault,
  input logic        rsp_buserr,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic [31:0] mem_rdata,
  input logic        mem_err
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_ack) |-> !req_ready); // R11
  AST_NO_MEM_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> !mem_req); // R11
  AST_ONE_FAIL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> !(rsp_fault && rsp_buserr)); // R6
  AST_BUSERR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> rsp_ack && rsp_buserr && !rsp_fault); // R6
  AST_ABSENT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_err && !mem_rdata[0] |=> rsp_ack && rsp_fault); // R3
  AST_FAIL_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack && (rsp_fault || rsp_buserr) |-> rsp_paddr == 32'd0); // R3
endmodule

bind pt_walker ptw_checker u_ptw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_ack    (rsp_ack),
  .rsp_paddr  (rsp_paddr),
  .rsp_fault  (rsp_fault),
  .rsp_buserr (rsp_buserr),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .mem_rdata  (mem_rdata),
  .mem_err    (mem_err)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam logic [19:0] ROOT_PN = 20'h00100;
  localparam logic [31:0] L2_BASE = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_ack, rsp_fault, rsp_buserr, rsp_write, mem_req;
  logic [31:0] rsp_paddr, rsp_vaddr, mem_addr;
  logic [5:0]  rsp_attr;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        flush_all = 1'b0, inval_en = 1'b0;
  logic [19:0] inval_vpn = '0;

  int errs = 0, checks = 0, mem_cnt = 0, wait_c = 0;
  logic        mv [8];
  logic [19:0] mvpn [8];
  int          mptr = 0;

  always #5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .tbl_pn(ROOT_PN),
    .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
    .rsp_fault(rsp_fault), .rsp_buserr(rsp_buserr), .rsp_vaddr(rsp_vaddr),
    .rsp_write(rsp_write), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .flush_all(flush_all), .inval_en(inval_en), .inval_vpn(inval_vpn)
  );

  // Table memory: {err, word}. Unknown addresses answer with an error.
  function automatic logic [32:0] mem_model(input logic [31:0] a);
    logic [9:0] i0, i1;
    logic [19:0] ppn;
    i0 = a[11:2];
    if (a[31:12] == ROOT_PN) begin
      if (i0 == 10'd6) return {1'b1, 32'h0};
      if (i0 % 4 == 3) return {1'b0, 32'h0000_0A50};
      return {1'b0, (L2_BASE + ({22'd0, i0} << 12)) | 32'h0000_0A51};
    end
    if (a >= L2_BASE && a < L2_BASE + 32'h0040_0000) begin
      i1 = 10'((a - L2_BASE) >> 12);
      if (i0 == 10'd9) return {1'b1, 32'h0};
      ppn = {i1, i0} ^ 20'h5A3C1;
      return {1'b0, ppn, 3'b000, i0[5:0], (i0 % 7) != 0, (i0 % 3) != 0, (i0 % 5) != 4};
    end
    return {1'b1, 32'hDEAD_0000};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Memory responder: 0..2 wait cycles per read.
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      mem_err = 1'b0;
      if (mem_req) begin
        if (wait_c == 0) begin
          {mem_err, mem_rdata} = mem_model(mem_addr);
          mem_ack = 1'b1;
          mem_cnt++;
          wait_c = $urandom % 3;
        end else begin
          wait_c--;
        end
      end
    end
  end

  task automatic do_flush();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    for (int i = 0; i < 8; i++) mv[i] = 1'b0;
  endtask

  task automatic do_inval(input logic [19:0] vpn);
    @(negedge clk); inval_en = 1'b1; inval_vpn = vpn;
    @(negedge clk); inval_en = 1'b0;
    for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == vpn) mv[i] = 1'b0;
  endtask

  // kind: 0 ok, 1 fault, 2 bus error. rtag labels the read-count check.
  task automatic translate(input logic [31:0] va, input bit w, input string rtag);
    logic [32:0] l1, l2;
    int   kind, reads, c0, cyc;
    bit   hit, perm_fail, busy_bad;
    logic [31:0] ep;
    logic [5:0]  ea;
    string ktag, rt;
    hit = 0; perm_fail = 0; ep = '0; ea = '0; kind = 0; busy_bad = 0;
    for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == va[31:12]) hit = 1;
    l1 = mem_model({ROOT_PN, va[31:22], 2'b00});
    l2 = mem_model({l1[31:12], va[21:12], 2'b00});
    if (hit) reads = 0;
    else if (l1[32]) begin kind = 2; reads = 1; end
    else if (!l1[0]) begin kind = 1; reads = 1; end
    else begin
      reads = 2;
      if (l2[32]) kind = 2;
      else if (!l2[0]) kind = 1;
      else begin
        mv[mptr] = 1'b1; mvpn[mptr] = va[31:12]; mptr = (mptr + 1) % 8;
      end
    end
    if (kind == 0) begin
      if (w ? !l2[2] : !l2[1]) begin kind = 1; perm_fail = 1; end
      else begin ep = {l2[31:12], va[11:0]}; ea = l2[8:3]; end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    c0 = mem_cnt;
    req_valid = 1'b1; req_vaddr = va; req_write = w;
    @(posedge clk); #1 req_valid = 1'b0;
    cyc = 0;
    @(negedge clk);
    while (!rsp_ack && cyc < 60) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk); cyc++;
    end
    chk(rsp_ack && !busy_bad, "R11", {63'd0, busy_bad}, 64'd0);
    ktag = (kind == 2) ? "R6" : (kind == 1) ? (perm_fail ? "R5" : "R3") : "R4";
    chk({rsp_buserr, rsp_fault} == 2'(kind), ktag, {62'd0, rsp_buserr, rsp_fault}, 64'(kind));
    chk(rsp_paddr == ep, (kind == 0) ? "R4" : "R3", 64'(rsp_paddr), 64'(ep));
    chk(rsp_attr == ea, (kind == 0) ? "R4" : "R3", 64'(rsp_attr), 64'(ea));
    chk(rsp_vaddr == va && rsp_write == w, "R12", {31'd0, rsp_write, rsp_vaddr}, {31'd0, w, va});
    rt = (rtag != "") ? rtag : (hit ? "R7" : "R2");
    chk(mem_cnt - c0 == reads, rt, 64'(mem_cnt - c0), 64'(reads));
    @(negedge clk);
    chk(!rsp_ack, "R11", {63'd0, rsp_ack}, 64'd0);
  endtask

  function automatic logic [31:0] va_of(input int v1, input int v0, input int ofs);
    return {10'(v1), 10'(v0), 12'(ofs)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R11: watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int pk[9];
    void'($urandom(32'd7331));
    for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; mvpn[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_ack, "R1", {61'd0, req_ready, mem_req, rsp_ack}, 64'b100);

    // R2 R4: first walk, then R7 the same page from the cache
    translate(va_of(0, 1, 12'h234), 1'b0, "R2");
    translate(va_of(0, 1, 12'hFFF), 1'b0, "R7");
    // R5: page 3 is write-only, page 7 is read-only
    translate(va_of(0, 3, 12'h010), 1'b0, "");
    translate(va_of(0, 3, 12'h010), 1'b1, "R7");
    translate(va_of(0, 7, 12'h000), 1'b1, "");
    // R3: absent at level one, absent at level two
    translate(va_of(3, 2, 12'h400), 1'b0, "");
    translate(va_of(1, 4, 12'h400), 1'b1, "");
    // R6: bus errors at both levels, nothing cached
    translate(va_of(6, 1, 12'h000), 1'b0, "");
    translate(va_of(2, 9, 12'h000), 1'b0, "");
    translate(va_of(2, 9, 12'h000), 1'b0, "R6");
    // R8: nine distinct fills, the first page is evicted
    do_flush();
    pk = '{1, 2, 5, 7, 8, 10, 11, 13, 16};
    for (int i = 0; i < 9; i++) translate(va_of(5, pk[i], 0), 1'b1, "");
    translate(va_of(5, 2, 12'h004), 1'b1, "R8");
    translate(va_of(5, 1, 12'h008), 1'b1, "R8");
    // R9: flush forces walks again
    do_flush();
    translate(va_of(5, 5, 0), 1'b1, "R9");
    translate(va_of(5, 7, 0), 1'b0, "R9");
    // R10: single-page drop
    do_inval({10'd5, 10'd5});
    translate(va_of(5, 5, 12'h0AB), 1'b1, "R10");
    translate(va_of(5, 7, 12'h0CD), 1'b0, "R10");

    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 40;
      if (r == 0) do_flush();
      else if (r == 1) do_inval({10'($urandom % 8), 10'($urandom % 24)});
      translate(va_of($urandom % 8, $urandom % 24, $urandom % 4096), 1'($urandom % 2), "");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule